// File: doc/BRIEF.md
# Light Gun Position Latch

This block stands in for the beam-sensing circuit of a light gun. A trigger request arrives with the horizontal coordinate `trigX` and the vertical coordinate `trigY` at which the gun sees the beam. The block converts these coordinates into a target raster line and a target dot, and arms a comparison against the raster counter that the display timing logic supplies. The vertical coordinate is given in field lines. The block adds the vertical sync line count to it, then maps the result onto the frame counter line using the current field flag. The horizontal coordinate is offset by the horizontal sync width.

When the raster reaches the target line and dot, the block stores the raster position at that moment in a read-only position word. It then sends a one-cycle request to the peripheral DMA and interrupt logic and goes back to idle. A second trigger issued while the block is armed replaces the pending target. If the target line falls outside the frame, the request is dropped. Writes that arrive from the register bus never change the position word.

Top module: `gun_pos_latch`

## Requirements
- R1: A trigger sets the target line to 2*((trigY >> 1) + vsyncLines) + fieldOdd. `fieldOdd` is sampled in the trigger cycle. The low bit of the target line therefore selects the odd field (1) or the even field (0).
- R2: A trigger sets the target dot to trigX + hsyncWidth. A match needs `lineCount` equal to the target line and `dotCount` equal to the target dot in the same cycle.
- R3: One cycle after a match cycle, `gunPos` holds the matched `lineCount` in bits 31:16 and `dotCount` bits 9:0 in bits 9:0. All other bits are zero. `gunPos` changes at no other time.
- R4: `dmaReq` is high for exactly one cycle: the cycle that follows a match.
- R5: Register-bus writes (`regWrEn` with `regWrData`) have no effect on `gunPos`.
- R6: A trigger while armed replaces the pending target. A trigger in the same cycle as a match on the old target takes precedence, and that match produces no latch.
- R7: `armed` goes high after an accepted trigger. It goes low in the cycle after a match, so one trigger latches at most once.
- R8: If the target line is greater than or equal to `totalLines`, the request is dropped. In that case `armed` is low the next cycle and no latch follows.
- R9: After reset, `gunPos` is 0 and both `armed` and `dmaReq` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lineCount | input | LINE_W | Current raster line in the frame |
| dotCount | input | DOT_W | Current dot within the line |
| fieldOdd | input | 1 | Current field flag (1 = odd) |
| vsyncLines | input | LINE_W | Vertical sync length in lines |
| hsyncWidth | input | DOT_W | Horizontal sync width in dots |
| totalLines | input | LINE_W+1 | Number of lines per frame |
| trigValid | input | 1 | Trigger request strobe |
| trigX | input | DOT_W | Horizontal gun coordinate |
| trigY | input | LINE_W | Vertical gun coordinate in field lines |
| regWrEn | input | 1 | Register-bus write strobe aimed at the position word |
| regWrData | input | 32 | Register-bus write data |
| gunPos | output | 32 | Latched gun position word |
| dmaReq | output | 1 | One-cycle request to peripheral DMA/interrupt logic |
| armed | output | 1 | A target is pending |

## Verification
The hardest case to reach from the ports is a new trigger that lands in exactly the cycle the raster meets the old target. The stimulus arms a target first. It then follows the free-running raster that the bench itself generates. The replacement trigger is driven just before the edge at which the line and dot inputs equal the old target. A behavioural model is compared against the design on every clock. The model also covers out-of-frame drops, replacement and unrelated register writes that run throughout the test.

// File: rtl/gun_pos_pkg.sv
package gun_pos_pkg;
  localparam int POS_LINE_LSB = 16;
  localparam int POS_DOT_W    = 10;

  typedef struct packed {
    logic loadTarget;
    logic latchPos;
  } gunStrobes_t;
endpackage

// File: rtl/gun_ctrl.sv
module gun_ctrl
  import gun_pos_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        trigValid,
  input  logic        tgtInRange,
  input  logic        hit,
  output gunStrobes_t strobes,
  output logic        armed,
  output logic        dmaReq
);
  // A trigger takes precedence over a match in the same cycle.
  always_comb begin
    strobes.loadTarget = trigValid && tgtInRange;
    strobes.latchPos   = armed && hit && !trigValid;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      armed  <= 1'b0;
      dmaReq <= 1'b0;
    end else begin
      dmaReq <= strobes.latchPos;
      if (trigValid)             armed <= tgtInRange;
      else if (strobes.latchPos) armed <= 1'b0;
    end
  end
endmodule

// File: rtl/gun_datapath.sv
module gun_datapath
  import gun_pos_pkg::*;
#(
  parameter int LINE_W = 10,
  parameter int DOT_W  = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  gunStrobes_t       strobes,
  input  logic [LINE_W-1:0] lineCount,
  input  logic [DOT_W-1:0]  dotCount,
  input  logic              fieldOdd,
  input  logic [LINE_W-1:0] vsyncLines,
  input  logic [DOT_W-1:0]  hsyncWidth,
  input  logic [LINE_W:0]   totalLines,
  input  logic [DOT_W-1:0]  trigX,
  input  logic [LINE_W-1:0] trigY,
  output logic              tgtInRange,
  output logic              hit,
  output logic [31:0]       gunPos
);
  localparam int FL_W = LINE_W + 1;
  localparam int CL_W = LINE_W + 2;
  localparam int TD_W = DOT_W + 1;

  logic [FL_W-1:0]   fieldLine;
  logic [CL_W-1:0]   counterLine;
  logic [TD_W-1:0]   dotTarget;
  logic [LINE_W-1:0] tgtLine;
  logic [TD_W-1:0]   tgtDot;
  logic [31:0]       posWord;

  always_comb begin
    fieldLine   = FL_W'({1'b0, trigY} >> 1) + FL_W'(vsyncLines);
    counterLine = {fieldLine, fieldOdd};
    tgtInRange  = counterLine < CL_W'(totalLines);
    dotTarget   = TD_W'(trigX) + TD_W'(hsyncWidth);
    hit         = (lineCount == tgtLine) && (TD_W'(dotCount) == tgtDot);
    posWord     = '0;
    posWord[POS_LINE_LSB +: LINE_W] = lineCount;
    posWord[POS_DOT_W-1:0]          = dotCount[POS_DOT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tgtLine <= '0;
      tgtDot  <= '0;
      gunPos  <= '0;
    end else begin
      if (strobes.loadTarget) begin
        tgtLine <= counterLine[LINE_W-1:0];
        tgtDot  <= dotTarget;
      end
      if (strobes.latchPos) gunPos <= posWord;
    end
  end
endmodule

// File: rtl/gun_pos_latch.sv
module gun_pos_latch
  import gun_pos_pkg::*;
#(
  parameter int LINE_W = 10,
  parameter int DOT_W  = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [LINE_W-1:0] lineCount,
  input  logic [DOT_W-1:0]  dotCount,
  input  logic              fieldOdd,
  input  logic [LINE_W-1:0] vsyncLines,
  input  logic [DOT_W-1:0]  hsyncWidth,
  input  logic [LINE_W:0]   totalLines,
  input  logic              trigValid,
  input  logic [DOT_W-1:0]  trigX,
  input  logic [LINE_W-1:0] trigY,
  input  logic              regWrEn,
  input  logic [31:0]       regWrData,
  output logic [31:0]       gunPos,
  output logic              dmaReq,
  output logic              armed
);
  gunStrobes_t strobes;
  logic        tgtInRange;
  logic        hit;

  gun_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .trigValid(trigValid), .tgtInRange(tgtInRange),
    .hit(hit), .strobes(strobes), .armed(armed), .dmaReq(dmaReq)
  );

  gun_datapath #(.LINE_W(LINE_W), .DOT_W(DOT_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .lineCount(lineCount),
    .dotCount(dotCount), .fieldOdd(fieldOdd), .vsyncLines(vsyncLines),
    .hsyncWidth(hsyncWidth), .totalLines(totalLines), .trigX(trigX),
    .trigY(trigY), .tgtInRange(tgtInRange), .hit(hit), .gunPos(gunPos)
  );
endmodule

// File: rtl/gun_pos_latch_chk.sv
module gun_pos_latch_chk #(
  parameter int LINE_W = 10,
  parameter int DOT_W  = 10
) (
  input logic              clk,
  input logic              rstN,
  input logic [LINE_W-1:0] lineCount,
  input logic [DOT_W-1:0]  dotCount,
  input logic              trigValid,
  input logic              regWrEn,
  input logic [31:0]       regWrData,
  input logic [31:0]       gunPos,
  input logic              dmaReq,
  input logic              armed
);
  AST_POS_FORMAT: assert property (@(posedge clk) disable iff (!rstN)
    dmaReq |-> (gunPos[16 +: LINE_W] == $past(lineCount)) && (gunPos[9:0] == $past(dotCount[9:0]))); // R3
  AST_POS_ONLY_ON_REQ: assert property (@(posedge clk) disable iff (!rstN)
    !dmaReq |-> $stable(gunPos)); // R3
  AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    dmaReq |=> !dmaReq); // R4
  AST_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && (regWrData != gunPos)) |=> (dmaReq || (gunPos != $past(regWrData)))); // R5
  AST_TRIG_BEATS_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    trigValid |=> !dmaReq); // R6
  AST_DISARM_ON_HIT: assert property (@(posedge clk) disable iff (!rstN)
    dmaReq |-> !armed); // R7
  AST_REQ_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rstN)
    dmaReq |-> $past(armed)); // R7
endmodule

bind gun_pos_latch gun_pos_latch_chk #(.LINE_W(LINE_W), .DOT_W(DOT_W)) chk_i (
  .clk(clk), .rstN(rstN), .lineCount(lineCount), .dotCount(dotCount),
  .trigValid(trigValid), .regWrEn(regWrEn), .regWrData(regWrData),
  .gunPos(gunPos), .dmaReq(dmaReq), .armed(armed)
);

// File: tb/gun_pos_latch_tb_top.sv
module gun_pos_latch_tb_top;
  localparam int LW = 10;
  localparam int DW = 10;
  localparam int DOTS = 64;
  localparam int LINES = 40;
  localparam int VSY = 3;
  localparam int HSY = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [LW-1:0] lineCount = '0;
  logic [DW-1:0] dotCount = '0;
  logic fieldOdd = 1'b0;
  logic trigValid = 1'b0;
  logic [DW-1:0] trigX = '0;
  logic [LW-1:0] trigY = '0;
  logic regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] gunPos;
  logic dmaReq, armed;

  int nChecks = 0;
  int nFails = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  gun_pos_latch #(.LINE_W(LW), .DOT_W(DW)) dut_i (
    .clk(clk), .rstN(rstN), .lineCount(lineCount), .dotCount(dotCount),
    .fieldOdd(fieldOdd), .vsyncLines(LW'(VSY)), .hsyncWidth(DW'(HSY)),
    .totalLines((LW+1)'(LINES)), .trigValid(trigValid), .trigX(trigX),
    .trigY(trigY), .regWrEn(regWrEn), .regWrData(regWrData),
    .gunPos(gunPos), .dmaReq(dmaReq), .armed(armed)
  );

  // Free-running raster and background register-bus writes.
  always @(negedge clk) begin
    if (dotCount == DOTS - 1) begin
      dotCount <= '0;
      if (lineCount == LINES - 1) begin
        lineCount <= '0;
        fieldOdd  <= ~fieldOdd;
      end else lineCount <= lineCount + 1'b1;
    end else dotCount <= dotCount + 1'b1;
    regWrEn   <= (cyc % 3) == 0;
    regWrData <= {cyc[15:0], 16'hA5C3};
  end

  // Behavioural reference model.
  int mArmed = 0, mReq = 0, mTL = 0, mTD = 0;
  longint mGun = 0;
  always @(posedge clk) begin
    int cl;
    if (!rstN) begin
      mArmed = 0; mReq = 0; mTL = 0; mTD = 0; mGun = 0;
    end else begin
      mReq = 0;
      if (trigValid) begin
        cl = 2 * ((int'(trigY) / 2) + VSY) + int'(fieldOdd);
        if (cl < LINES) begin
          mArmed = 1; mTL = cl; mTD = int'(trigX) + HSY;
        end else mArmed = 0;
      end else if (mArmed == 1 && int'(lineCount) == mTL && int'(dotCount) == mTD) begin
        mGun = (longint'(lineCount) << 16) | (longint'(dotCount) & 1023);
        mReq = 1;
        mArmed = 0;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Per-cycle comparison against the model: R3 word, R4 pulse, R7 armed.
  always @(negedge clk) begin
    cyc++;
    if (rstN) begin
      chk(gunPos == 32'(mGun), "R3 gunPos vs model", gunPos, mGun);
      chk(dmaReq == mReq[0], "R4 dmaReq vs model", dmaReq, mReq);
      chk(armed == mArmed[0], "R7 armed vs model", armed, mArmed);
    end
    if (cyc > 150000) begin
      nFails++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

  bit lastField;

  task automatic trig(input int x, input int y);
    @(negedge clk);
    trigValid = 1'b1; trigX = DW'(x); trigY = LW'(y);
    #1 lastField = fieldOdd;
    @(negedge clk);
    trigValid = 1'b0;
  endtask

  task automatic waitReq(output bit got);
    got = 0;
    for (int i = 0; i < 3000 && !got; i++) begin
      @(negedge clk);
      #2 if (dmaReq) got = 1;
    end
  endtask

  function automatic longint expWord(input int y, input int x, input bit f);
    int line = 2 * ((y / 2) + VSY) + int'(f);
    return (longint'(line) << 16) | longint'(x + HSY);
  endfunction

  initial begin
    bit got;
    int tl, td;
    repeat (3) @(negedge clk);
    #2;
    chk(gunPos == 0, "R9 reset gunPos", gunPos, 0);
    chk(!armed, "R9 reset armed", armed, 0);
    chk(!dmaReq, "R9 reset dmaReq", dmaReq, 0);
    @(negedge clk) rstN = 1'b1;
    repeat (30) @(negedge clk);
    #2 chk(gunPos == 0, "R5 writes ignored before any hit", gunPos, 0);

    // R1/R2: basic hit, both field flags.
    for (int k = 0; k < 3; k++) begin
      trig(10 + k, 6 + k);
      #2 chk(armed, "R7 armed after trigger", armed, 1);
      waitReq(got);
      chk(got, "R4 request seen", got, 1);
      chk(gunPos == 32'(expWord(6 + k, 10 + k, lastField)), "R1 R2 target position",
          gunPos, expWord(6 + k, 10 + k, lastField));
      @(negedge clk); #2;
      chk(!dmaReq, "R4 single-cycle pulse", dmaReq, 0);
      chk(!armed, "R7 disarmed after hit", armed, 0);
    end

    // R6: replacement of a pending target.
    trig(10, 30);
    trig(20, 4);
    waitReq(got);
    chk(gunPos == 32'(expWord(4, 20, lastField)), "R6 replaced target latched",
        gunPos, expWord(4, 20, lastField));

    // R8: target line beyond frame is dropped.
    trig(3, 60);
    #2 chk(!armed, "R8 out-of-frame not armed", armed, 0);
    waitReq(got);
    chk(!got, "R8 no latch after drop", got, 0);

    // R6: trigger lands in the exact match cycle of the old target.
    trig(7, 8);
    tl = 2 * (4 + VSY) + int'(lastField);
    td = 7 + HSY;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      #1 if (int'(lineCount) == tl && int'(dotCount) == td) break;
    end
    trigValid = 1'b1; trigX = DW'(1); trigY = LW'(2);
    lastField = fieldOdd;
    @(negedge clk);
    trigValid = 1'b0;
    #2;
    chk(!dmaReq, "R6 trigger beats same-cycle match", dmaReq, 0);
    chk(armed, "R6 new target armed", armed, 1);
    waitReq(got);
    chk(gunPos == 32'(expWord(2, 1, lastField)), "R6 later hit uses new target",
        gunPos, expWord(2, 1, lastField));

    repeat (10) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule